// File: doc/BRIEF.md
# Software-Controlled Peripheral Reset Register

This block holds one 32-bit register in which each used bit drives the reset line of one peripheral. Software sets and clears the bits with plain writes. There is no write-enable mask and no completion flag. Each line keeps the level software last wrote until software writes it again.

The polarity of each line is a parameter. Most lines are active low, so a stored 0 puts the peripheral in reset. The one line selected by `ACT_HIGH_MASK` is active high. Bit positions outside `USED_MASK` have no line behind them.

Whenever a write changes a line, that line raises its own clock-stop request for a programmable number of timing steps. The caller supplies the steps as single-cycle `step_tick` pulses, for example one every 0.25 µs. The request lets the clock-gating logic hold the peripheral's clock off while reset is applied or removed. Each line has its own counter, so the lines run independently of each other.

Top module: `swrst_reg`

## Requirements
- R1: After `rst_n` is sampled low, every line reads back at its inactive level. With the default parameters `rd_data` is 0x003E7FFF, `rst_asserted` is 0 and `clk_stop` is 0.
- R2: When `wr_en` is high at a clock edge, each used bit takes the value of `wr_data` at that edge. `rd_data` then equals `wr_data & USED_MASK`, where the default `USED_MASK` is 0x007E7FFF (bits 0–14 and 17–22).
- R3: Unused bit positions (15, 16 and 23–31 by default) read as 0 and ignore writes. They never raise `rst_asserted` or `clk_stop`.
- R4: `rst_asserted[i]` is 1 exactly when line i is in reset. An active-low line is in reset when its stored bit is 0. An active-high line is in reset when its stored bit is 1; by default only bit 22 is active high. `rst_line` always equals the stored bits.
- R5: A write that changes a used bit raises that bit of `clk_stop` from the cycle in which the new value appears. The request stays up until `stop_steps` `step_tick` pulses have been counted, and drops after the last one.
- R6: A write that leaves a bit unchanged raises no clock-stop request for that bit.
- R7: The lines are independent. A change on one line raises `clk_stop` only for that line.
- R8: When `stop_steps` is 0, a change raises no clock-stop request.
- R9: A further change on a line while its request is still up reloads the counter with `stop_steps`.
- R10: Without a write, the stored bits never change, whatever `step_tick` does. A reset stays applied until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Value to write |
| stop_steps | input | STOP_W | Clock-stop length in steps |
| step_tick | input | 1 | One pulse per timing step |
| rd_data | output | 32 | Stored register value |
| rst_line | output | 32 | Physical reset line levels |
| rst_asserted | output | 32 | Per-line "in reset" indication |
| clk_stop | output | 32 | Per-line clock-stop request |

## Verification
A wrong stored bit shows at `rd_data` and `rst_line` in the cycle after the write edge. The same fault flips `rst_asserted` there and raises a spurious or missing `clk_stop` in that cycle. A wrong counter shows as a `clk_stop` request that ends one step early or late, or never ends; this is seen within `stop_steps` tick pulses. A wrong polarity parameter shows directly after reset, as a non-zero `rst_asserted` or a wrong `rd_data` value.

// File: rtl/swrst_pkg.sv
// Package: shared widths and the polarity helper for the software reset register.
// Assumes: a 32-bit register; polarity is given as an active-high flag per line.
package swrst_pkg;
    localparam int REG_W = 32;

    // Idle (inactive) level of a line with the given polarity
    function automatic logic idle_level(input logic act_high);
        return ~act_high;
    endfunction
endpackage

// File: rtl/swrst_stop_timer.sv
// Module: clock-stop down counter for one reset line.
// Loads a step count on request and counts it down on step ticks.
// Assumes: load takes priority over a tick in the same cycle.
module swrst_stop_timer #(
    parameter int STOP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STOP_W-1:0] load_val,
    input  logic              tick,
    output logic              busy
);
    logic [STOP_W-1:0] cnt_q;

    // Count down remaining stop steps; reload on a new line change
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R5
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !load) |=> busy);
    // R5
    end_on_last_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == STOP_W'(1) && tick && !load) |=> !busy);
    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> busy);
endmodule

// File: rtl/swrst_line.sv
// Module: one software reset line with fixed polarity.
// Stores the line level, detects a write that changes it, and starts the
// clock-stop timer for that change.
// Assumes: ACT_HIGH selects an active-high line; otherwise it is active low.
module swrst_line
    import swrst_pkg::*;
#(
    parameter bit ACT_HIGH = 1'b0,
    parameter int STOP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [STOP_W-1:0] stop_steps,
    input  logic              tick,
    output logic              line_q,
    output logic              asserted,
    output logic              clk_stop
);
    logic level_q;
    logic changed;

    // Hold the line level; reset puts it at its idle level
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= idle_level(ACT_HIGH);
        else if (wr_en)
            level_q <= wr_bit;
    end

    // Flag a write that flips the stored level
    always_comb changed = wr_en && (wr_bit != level_q);

    swrst_stop_timer #(.STOP_W(STOP_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (changed),
        .load_val (stop_steps),
        .tick     (tick),
        .busy     (clk_stop)
    );

    assign line_q   = level_q;
    assign asserted = ACT_HIGH ? level_q : ~level_q;

    // R10
    stable_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(level_q));
    // R5
    stop_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit != level_q && stop_steps != '0) |=> clk_stop);
    // R6
    no_stop_on_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit == level_q && !clk_stop) |=> !clk_stop);
endmodule

// File: rtl/swrst_reg.sv
// Module: software reset register, top level.
// One line per used bit position, each with its own polarity and clock-stop
// timer; unused positions read 0 and ignore writes.
// Assumes: step_tick is a single-cycle pulse per timing step.
module swrst_reg
    import swrst_pkg::*;
#(
    parameter logic [REG_W-1:0] USED_MASK     = 32'h007E_7FFF,
    parameter logic [REG_W-1:0] ACT_HIGH_MASK = 32'h0040_0000,
    parameter int               STOP_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [STOP_W-1:0] stop_steps,
    input  logic              step_tick,
    output logic [REG_W-1:0]  rd_data,
    output logic [REG_W-1:0]  rst_line,
    output logic [REG_W-1:0]  rst_asserted,
    output logic [REG_W-1:0]  clk_stop
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (USED_MASK[i]) begin : g_used
            swrst_line #(
                .ACT_HIGH (ACT_HIGH_MASK[i]),
                .STOP_W   (STOP_W)
            ) u_line (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (wr_en),
                .wr_bit     (wr_data[i]),
                .stop_steps (stop_steps),
                .tick       (step_tick),
                .line_q     (rst_line[i]),
                .asserted   (rst_asserted[i]),
                .clk_stop   (clk_stop[i])
            );
        end else begin : g_unused
            assign rst_line[i]     = 1'b0;
            assign rst_asserted[i] = 1'b0;
            assign clk_stop[i]     = 1'b0;
        end
    end

    assign rd_data = rst_line;

    // R7
    single_change_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $countones((wr_data ^ rd_data) & USED_MASK) == 1
         && clk_stop == '0 && stop_steps != '0) |=> $onehot0(clk_stop));
endmodule

// File: tb/swrst_reg_tb.sv
module swrst_reg_tb;
    localparam logic [31:0] USED = 32'h007E_7FFF;
    localparam logic [31:0] HIGH = 32'h0040_0000;
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{32'hFFFF_FFFF, 32'h0000_0000,
        32'h003E_7FFF, 32'h003E_7FFF, 32'h1234_5678, 32'hA5A5_A5A5};

    logic clk = 0, rst_n = 0, wr_en = 0, step_tick = 0;
    logic [31:0] wr_data = '0;
    logic [3:0]  stop_steps = 4'd3;
    logic [31:0] rd_data, rst_line, rst_asserted, clk_stop;
    int errors = 0, checks = 0;
    logic done = 0;

    always #5 clk = ~clk;

    swrst_reg u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .stop_steps(stop_steps), .step_tick(step_tick), .rd_data(rd_data),
        .rst_line(rst_line), .rst_asserted(rst_asserted), .clk_stop(clk_stop));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] v);
        @(negedge clk); wr_en = 1; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic do_tick();
        @(negedge clk); step_tick = 1;
        @(negedge clk); step_tick = 0;
    endtask

    function automatic logic [31:0] exp_asserted(input logic [31:0] v);
        return ((~v & ~HIGH) | (v & HIGH)) & USED;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset value", rd_data, 32'h003E_7FFF);
        chk("R1 no stop after reset", clk_stop, 32'h0);
        chk("R1 R4 nothing asserted", rst_asserted, 32'h0);

        prev = rd_data;
        for (int k = 0; k < NV; k++) begin
            do_write(VEC[k]);
            chk("R2 readback", rd_data, VEC[k] & USED);
            chk("R4 line level", rst_line, VEC[k] & USED);
            chk("R4 asserted polarity", rst_asserted, exp_asserted(VEC[k]));
            chk("R5 R6 R7 R3 stop on changed bits", clk_stop, (prev ^ VEC[k]) & USED);
            do_tick(); do_tick();
            chk("R5 stop held before last step", clk_stop, (prev ^ VEC[k]) & USED);
            do_tick();
            chk("R5 stop released after steps", clk_stop, 32'h0);
            prev = VEC[k] & USED;
        end

        // R3: write only unused positions over a zero register
        do_write(32'h0);
        repeat (3) do_tick();
        do_write(~USED);
        chk("R3 unused ignore writes", rd_data, 32'h0);
        chk("R3 unused no stop", clk_stop, 32'h0);

        // R7: single line change
        do_write(32'h0000_0100);
        chk("R7 only line 8 stopped", clk_stop, 32'h0000_0100);
        repeat (3) do_tick();

        // R8: zero step count
        stop_steps = 4'd0;
        do_write(32'h0040_0001);
        chk("R8 no stop with zero steps", clk_stop, 32'h0);
        chk("R4 bit22 active high asserted", rst_asserted & HIGH, HIGH);

        // R9: reload while busy
        stop_steps = 4'd2;
        do_write(32'h0040_0000);
        do_tick();
        chk("R9 busy after one step", clk_stop, 32'h1);
        do_write(32'h0040_0001);
        do_tick();
        chk("R9 reloaded still busy", clk_stop, 32'h1);
        do_tick();
        chk("R9 released after reload steps", clk_stop, 32'h0);

        // R10: no write, many ticks
        repeat (20) do_tick();
        chk("R10 value held", rd_data, 32'h0040_0001);
        chk("R10 reset still applied", rst_asserted, USED & ~32'h1);

        // R1: reset again restores idle
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 reset restores idle", rd_data, 32'h003E_7FFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule